// File: doc/BRIEF.md
# Programmable Line Clamp and Preblank Pulse Generator

This block drives two active-low timing strobes for an image-sensor analog front end, one that marks the optical-black clamp interval and one that marks the preblank interval of each line. Both strobes are shaped within the line by a pixel counter. Each has a starting level and two pixel positions at which the level flips. A position of 8191 means that flip is unused. Every vertical sequence owns its own shape for each strobe. The vertical-timing logic upstream presents the index of the sequence that governs the current field region, and the block takes that shape at each line start.

Three line windows per strobe, shared by all sequences, can suppress that strobe over chosen line ranges of the field. The stored shapes are not altered. A line counter, cleared by the field-start strobe and advanced by the line-start strobe (HD), decides whether a line lies inside a window. Software loads shapes and windows through a plain write port. A shape write reaches the output only at the next line start, so a line that is already running is never cut mid-pulse. The register port and the strobes are plain control pins. No data stream passes through the block.

Top module: `line_pulse_gen`

## Requirements
- R1: After reset both outputs are high, every shape holds start level 1 with both flip positions at 8191, and every window boundary holds 0xFFF.
- R2: A write with `wr_addr[3]`=0 loads the shape of strobe `wr_addr[2]` (0 clamp, 1 preblank) for sequence `wr_addr[1:0]`, with `wr_data[12:0]` as the first flip, `[25:13]` as the second flip and `[26]` as the start level. A write with `wr_addr[3]`=1 loads window `wr_addr[1:0]` (0 to 2) of that strobe, with `wr_data[11:0]` as the first line and `[23:12]` as the last line.
- R3: The pixel count is 0 in the clock cycle that follows the edge at which HD is high, and it rises by one each cycle after that.
- R4: With no window active, a strobe in pixel p equals start XOR (p ≥ first flip) XOR (p ≥ second flip). The order of the two flips does not matter.
- R5: A flip position of 8191 never changes the level.
- R6: The shape used for a whole line is the one of the sequence index sampled at HD. An index change in mid-line has no effect until the next HD.
- R7: A shape write in mid-line leaves the current line unchanged and takes effect at the next HD.
- R8: The field-start strobe sets the line count to 0, also in mid-line. Each HD without a field start adds one. When both fall in the same cycle, the line count is 0.
- R9: While the line count is inside an enabled window of a strobe, first and last line included, that strobe is high whatever its shape. The other strobe is not affected.
- R10: A window whose first or last line is 0xFFF is disabled.
- R11: The two strobes are independent: programming one leaves the other at its own shape.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd | input | 1 | Line-start strobe, one cycle |
| field_start | input | 1 | Field-start strobe, one cycle |
| seq_sel | input | 2 | Index of the vertical sequence in force |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 27 | Register write data |
| clamp_n | output | 1 | Optical-black clamp strobe, active low |
| blank_n | output | 1 | Preblank strobe, active low |

## Verification
The field-start strobe and HD can land on the same edge, and the line count must then be 0 rather than 1. The bench asserts both together and checks that a window that covers only line 0 suppresses the clamp strobe in that line, then lets a second HD move to line 1, where the strobe must return to its shape. A field start on its own in mid-line is also driven, and the output must go high within one cycle when line 0 is masked.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
  localparam int PIX_W  = 13;
  localparam int LINE_W = 12;
  localparam logic [PIX_W-1:0]  PIX_SENT  = '1;
  localparam logic [LINE_W-1:0] LINE_SENT = '1;
  localparam int DATA_W = 1 + 2 * PIX_W;

  typedef struct packed {
    logic             lvl;
    logic [PIX_W-1:0] flip_b;
    logic [PIX_W-1:0] flip_a;
  } shape_t;

  typedef struct packed {
    logic [LINE_W-1:0] last;
    logic [LINE_W-1:0] first;
  } win_t;

  localparam shape_t SHAPE_RST = '{lvl: 1'b1, flip_b: PIX_SENT, flip_a: PIX_SENT};
  localparam win_t   WIN_RST   = '{last: LINE_SENT, first: LINE_SENT};
endpackage

// File: rtl/lpg_regfile.sv
module lpg_regfile
  import lpg_pkg::*;
#(
  parameter int NUM_SEQ = 4,
  parameter int NUM_WIN = 3,
  parameter int IDX_W   = 2,
  parameter int ADDR_W  = IDX_W + 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  output shape_t [1:0][NUM_SEQ-1:0]        shapes,
  output win_t   [1:0][NUM_WIN-1:0]        wins
);
  for (genvar p = 0; p < 2; p++) begin : g_pulse
    for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq
      logic hit;
      assign hit = wr_en && (wr_addr == {1'b0, 1'(p), IDX_W'(s)});
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   shapes[p][s] <= SHAPE_RST;
        else if (hit) shapes[p][s] <= shape_t'(wr_data);
      end
    end
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      logic hit;
      assign hit = wr_en && (wr_addr == {1'b1, 1'(p), IDX_W'(w)});
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   wins[p][w] <= WIN_RST;
        else if (hit) wins[p][w] <= win_t'(wr_data[2*LINE_W-1:0]);
      end
    end
  end
endmodule

// File: rtl/lpg_counters.sv
module lpg_counters
  import lpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hd,
  input  logic              field_start,
  output logic [PIX_W-1:0]  pix_cnt,
  output logic [LINE_W-1:0] line_cnt,
  output logic [PIX_W-1:0]  pix_nxt,
  output logic [LINE_W-1:0] line_nxt
);
  localparam logic [PIX_W-1:0]  PIX_MAX  = '1;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  always_comb begin
    if (hd)                     pix_nxt = '0;
    else if (pix_cnt != PIX_MAX) pix_nxt = pix_cnt + 1'b1;
    else                        pix_nxt = pix_cnt;

    if (field_start)                 line_nxt = '0;
    else if (hd && line_cnt != LINE_MAX) line_nxt = line_cnt + 1'b1;
    else                             line_nxt = line_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_cnt  <= '0;
      line_cnt <= '0;
    end else begin
      pix_cnt  <= pix_nxt;
      line_cnt <= line_nxt;
    end
  end

  // R3
  pix_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hd |=> pix_cnt == '0);

  // R3
  pix_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hd && pix_cnt != PIX_MAX) |=> pix_cnt == PIX_W'($past(pix_cnt) + 1'b1));

  // R8
  line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> line_cnt == '0);

  // R8
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hd && !field_start && line_cnt != LINE_MAX) |=> line_cnt == LINE_W'($past(line_cnt) + 1'b1));
endmodule

// File: rtl/lpg_shaper.sv
module lpg_shaper
  import lpg_pkg::*;
#(
  parameter int NUM_SEQ = 4,
  parameter int NUM_WIN = 3,
  parameter int SEQ_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hd,
  input  logic [SEQ_W-1:0]          seq_sel,
  input  shape_t [NUM_SEQ-1:0]      bank,
  input  win_t   [NUM_WIN-1:0]      wins,
  input  logic [PIX_W-1:0]          pix_nxt,
  input  logic [LINE_W-1:0]         line_nxt,
  output logic                      pulse_n
);
  shape_t act_q, act_nxt;
  logic   masked, level;

  // the shape in force is frozen for the whole line
  always_comb act_nxt = hd ? bank[seq_sel] : act_q;

  always_comb begin
    masked = 1'b0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (wins[w].first != LINE_SENT && wins[w].last != LINE_SENT &&
          line_nxt >= wins[w].first && line_nxt <= wins[w].last)
        masked = 1'b1;
    end
    level = act_nxt.lvl
          ^ (act_nxt.flip_a != PIX_SENT && pix_nxt >= act_nxt.flip_a)
          ^ (act_nxt.flip_b != PIX_SENT && pix_nxt >= act_nxt.flip_b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= SHAPE_RST;
      pulse_n <= 1'b1;
    end else begin
      act_q   <= act_nxt;
      pulse_n <= masked | level;
    end
  end

  // R7
  shape_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hd |=> $stable(act_q));

  // R5
  idle_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hd && act_q.flip_a == PIX_SENT && act_q.flip_b == PIX_SENT && act_q.lvl)
      |=> pulse_n);
endmodule

// File: rtl/line_pulse_gen.sv
module line_pulse_gen
  import lpg_pkg::*;
#(
  parameter int NUM_SEQ = 4,
  parameter int NUM_WIN = 3,
  localparam int SEQ_W  = (NUM_SEQ > 1) ? $clog2(NUM_SEQ) : 1,
  localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int IDX_W  = (SEQ_W > WIN_W) ? SEQ_W : WIN_W,
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hd,
  input  logic              field_start,
  input  logic [SEQ_W-1:0]  seq_sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              clamp_n,
  output logic              blank_n
);
  shape_t [1:0][NUM_SEQ-1:0] shapes;
  win_t   [1:0][NUM_WIN-1:0] wins;
  logic [PIX_W-1:0]  pix_cnt, pix_nxt;
  logic [LINE_W-1:0] line_cnt, line_nxt;
  logic [1:0]        pn;

  lpg_regfile #(.NUM_SEQ(NUM_SEQ), .NUM_WIN(NUM_WIN), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .shapes(shapes), .wins(wins));

  lpg_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .hd(hd), .field_start(field_start),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt), .pix_nxt(pix_nxt), .line_nxt(line_nxt));

  for (genvar p = 0; p < 2; p++) begin : g_shp
    lpg_shaper #(.NUM_SEQ(NUM_SEQ), .NUM_WIN(NUM_WIN), .SEQ_W(SEQ_W)) u_shp (
      .clk(clk), .rst_n(rst_n), .hd(hd), .seq_sel(seq_sel),
      .bank(shapes[p]), .wins(wins[p]), .pix_nxt(pix_nxt), .line_nxt(line_nxt),
      .pulse_n(pn[p]));
  end

  assign clamp_n = pn[0];
  assign blank_n = pn[1];

  // R1
  rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rst_n) && !$past(hd)) |-> (clamp_n && blank_n));
endmodule

// File: tb/line_pulse_gen_bench.sv
module line_pulse_gen_bench;
  logic clk = 0, rst_n = 0, hd = 0, field_start = 0, wr_en = 0;
  logic [1:0]  seq_sel = 0;
  logic [3:0]  wr_addr = 0;
  logic [26:0] wr_data = 0;
  logic clamp_n, blank_n;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  line_pulse_gen u_line_pulse_gen (
    .clk(clk), .rst_n(rst_n), .hd(hd), .field_start(field_start), .seq_sel(seq_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clamp_n(clamp_n), .blank_n(blank_n));

  // {start level, first flip, second flip, pixel probed, expected level}
  localparam logic [40:0] VEC [13] = '{
    {1'b0, 13'd10,   13'd20,   13'd5,  1'b0},
    {1'b0, 13'd10,   13'd20,   13'd10, 1'b1},
    {1'b0, 13'd10,   13'd20,   13'd15, 1'b1},
    {1'b0, 13'd10,   13'd20,   13'd20, 1'b0},
    {1'b0, 13'd10,   13'd20,   13'd30, 1'b0},
    {1'b1, 13'd0,    13'd8191, 13'd0,  1'b0},
    {1'b1, 13'd0,    13'd8191, 13'd50, 1'b0},
    {1'b0, 13'd8191, 13'd8191, 13'd3,  1'b0},
    {1'b1, 13'd8191, 13'd4,    13'd9,  1'b0},
    {1'b1, 13'd30,   13'd8,    13'd7,  1'b1},
    {1'b1, 13'd30,   13'd8,    13'd8,  1'b0},
    {1'b1, 13'd30,   13'd8,    13'd29, 1'b0},
    {1'b1, 13'd30,   13'd8,    13'd30, 1'b1}
  };

  task automatic check(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [26:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wr_shape(input bit pulse, input logic [1:0] seq, input logic lvl,
                          input logic [12:0] fa, input logic [12:0] fb);
    wr({1'b0, pulse, seq}, {lvl, fb, fa});
  endtask

  task automatic wr_win(input bit pulse, input logic [1:0] w, input logic [11:0] first,
                        input logic [11:0] last);
    wr({1'b1, pulse, w}, {3'b0, last, first});
  endtask

  // leaves the caller in the middle of pixel 0
  task automatic line_start(input bit with_field);
    @(negedge clk); hd = 1; field_start = with_field;
    @(negedge clk); hd = 0; field_start = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(clamp_n, 1'b1, "R1 clamp at reset");
    check(blank_n, 1'b1, "R1 blank at reset");
    rst_n = 1;
    line_start(0);
    repeat (3) @(negedge clk);
    check(clamp_n, 1'b1, "R1 default clamp shape");
    check(blank_n, 1'b1, "R1 default blank shape");

    // table walk: clamp of sequence 0, preblank left at its default
    for (int i = 0; i < 13; i++) begin
      logic lvl; logic [12:0] fa, fb, p; logic e;
      {lvl, fa, fb, p, e} = VEC[i];
      wr_shape(0, 2'd0, lvl, fa, fb);
      line_start(0);
      repeat (p) @(negedge clk);
      check(clamp_n, e, (fa == 13'd8191 || fb == 13'd8191) ? "R5 R3" : "R4 R3");
      check(blank_n, 1'b1, "R11 blank untouched");
    end

    // R6: sequence index taken at HD only
    wr_shape(0, 2'd0, 1'b1, 13'd8191, 13'd8191);
    wr_shape(0, 2'd1, 1'b0, 13'd8191, 13'd8191);
    seq_sel = 2'd1;
    line_start(0);
    repeat (2) @(negedge clk);
    check(clamp_n, 1'b0, "R6 sequence 1 shape");
    seq_sel = 2'd0;
    repeat (2) @(negedge clk);
    check(clamp_n, 1'b0, "R6 mid-line index change ignored");
    line_start(0);
    check(clamp_n, 1'b1, "R6 sequence 0 at next line");

    // R7: mid-line write waits for the next line
    wr_shape(0, 2'd0, 1'b0, 13'd8191, 13'd8191);
    repeat (2) @(negedge clk);
    check(clamp_n, 1'b1, "R7 write held until line start");
    line_start(0);
    check(clamp_n, 1'b0, "R7 write applied at line start");

    // R11: preblank on its own shape
    wr_shape(1, 2'd0, 1'b0, 13'd8191, 13'd8191);
    line_start(0);
    check(blank_n, 1'b0, "R11 blank shape");

    // R2 R9 R10: windows on the clamp strobe only
    wr_win(0, 2'd0, 12'd2, 12'd3);
    wr_win(0, 2'd1, 12'd0, 12'd0);
    wr_win(0, 2'd2, 12'd5, 12'hFFF);
    line_start(1);
    check(clamp_n, 1'b1, "R8 field and line start together give line 0");
    check(blank_n, 1'b0, "R9 blank not masked on line 0");
    for (int ln = 1; ln <= 5; ln++) begin
      line_start(0);
      @(negedge clk);
      check(clamp_n, (ln == 2 || ln == 3) ? 1'b1 : 1'b0,
            ln == 5 ? "R10 disabled window" : "R9 inclusive window");
      check(blank_n, 1'b0, "R9 blank independent of clamp windows");
    end

    // R8: field start alone in mid-line
    @(negedge clk); field_start = 1;
    @(negedge clk); field_start = 0;
    check(clamp_n, 1'b1, "R8 mid-line field start to line 0");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule